// File: doc/BRIEF.md
# Lockable Watchdog Timer

A bus-mapped watchdog for a chip's always-on domain. Software programs a period into a load register and sets a run bit. A 32-bit counter then counts down once per clock. Each time the counter expires, it raises an interrupt and starts again from the programmed period. If software has not acknowledged the interrupt by the next expiry, and the reset-request enable is set, the block raises a reset request. That request stays high until the block itself is reset.

Register writes can be fenced off by a lock register. Writing one fixed 32-bit key (0x1ACCE551) opens the lock. Any other value written there closes it. While the lock is closed, only the lock register itself accepts writes. Reads stay open at all times. Reads are combinational: `rdata_o` shows the addressed register while `rd_en_i` is high, and reads 0 otherwise.

Top module: `lock_wdt`

## Requirements
- R1: After `rst_ni` is released, the following hold until the first write:
  - the load register (offset 0x000) reads 0xFFFFFFFF;
  - the current count (0x004) reads 0xFFFFFFFF;
  - control (0x008) reads 0;
  - lock (0xC00) reads 0;
  - `irq_o` and `rst_req_o` are low.
- R2: A write of 0x1ACCE551 to 0xC00 makes the lock read 0x00000000 (open). A write of any other value makes it read 0x00000001 (closed).
- R3: While the lock is closed, writes to load, control and interrupt clear (0x00C) change nothing.
- R4: Control bit 0 is the run bit.
  - Counting: while bit 0 is 1, the current count drops by one per clock.
  - Holding: while bit 0 is 0, the count holds.
  - Restart: a write that changes bit 0 from 0 to 1 reloads the count from the load register. It does not resume from the stopped value.
- R5: With load value L and the run bit set, an expiry happens on the L-th clock after a reload. At that clock, bit 0 of raw status (0x010) becomes 1 and the count reloads to L.
- R6: Bit 0 of masked status (0x014) and `irq_o` both equal raw status gated by the run bit.
- R7: A write to 0x00C with any data clears raw status and reloads the count from the load register.
- R8: Reset request on a second expiry:
  - Control bit 1 is the reset-request enable.
  - An expiry that finds raw status already set, while bit 1 is 1, raises `rst_req_o`.
  - `rst_req_o` then stays high until `rst_ni`, even if the interrupt is later cleared.
  - With bit 1 at 0, `rst_req_o` stays low.
- R9: A write to the load register also reloads the count with the new value at once.
- R10: A load value of 0 behaves as 1, so the counter expires on every clock while running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W (12) | Byte offset of the register |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data, valid in the same cycle as `rd_en_i` |
| irq_o | output | 1 | Watchdog interrupt (masked by the run bit) |
| rst_req_o | output | 1 | Sticky reset request |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, 12-bit offsets, the standard key and an all-ones reset load. Because software reprograms the load register to small values (0, 2, 3 and 5), full expiry periods, double expiries and the load-of-zero case all fit in a few dozen clocks. The all-ones reset value is still checked through the register reads. Two resets split the run:
- The first reset covers the counting, expiry, clear and reset-request sequence.
- The second reset covers locking, with an interrupt left pending, so that a blocked clear is visible at the status port.

// File: rtl/lock_wdt_pkg.sv
package lock_wdt_pkg;
  localparam int unsigned OFF_LOAD  = 32'h000;
  localparam int unsigned OFF_CUR   = 32'h004;
  localparam int unsigned OFF_CTRL  = 32'h008;
  localparam int unsigned OFF_CLR   = 32'h00C;
  localparam int unsigned OFF_RAW   = 32'h010;
  localparam int unsigned OFF_MASK  = 32'h014;
  localparam int unsigned OFF_LOCK  = 32'hC00;

  typedef struct packed {
    logic rst_en;
    logic run_en;
  } ctrl_t;
endpackage

// File: rtl/lock_wdt_regs.sv
module lock_wdt_regs
  import lock_wdt_pkg::*;
#(
  parameter int unsigned        DATA_W    = 32,
  parameter int unsigned        ADDR_W    = 12,
  parameter logic [DATA_W-1:0]  KEY       = 32'h1ACCE551,
  parameter logic [DATA_W-1:0]  LOAD_INIT = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              raw_i,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] reload_val_o,
  output logic              reload_o,
  output logic              clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned PAD_W = DATA_W - 2;

  logic              locked_q;
  logic [DATA_W-1:0] load_q;
  ctrl_t             ctrl_q;

  logic sel_load, sel_cur, sel_ctrl, sel_clr, sel_raw, sel_mask, sel_lock;
  logic wr_ok, load_wr, ctrl_wr, start;

  assign sel_load = addr_i == ADDR_W'(OFF_LOAD);
  assign sel_cur  = addr_i == ADDR_W'(OFF_CUR);
  assign sel_ctrl = addr_i == ADDR_W'(OFF_CTRL);
  assign sel_clr  = addr_i == ADDR_W'(OFF_CLR);
  assign sel_raw  = addr_i == ADDR_W'(OFF_RAW);
  assign sel_mask = addr_i == ADDR_W'(OFF_MASK);
  assign sel_lock = addr_i == ADDR_W'(OFF_LOCK);

  assign wr_ok   = wr_en_i && !locked_q;
  assign load_wr = wr_ok && sel_load;
  assign ctrl_wr = wr_ok && sel_ctrl;
  assign clr_o   = wr_ok && sel_clr;
  // only a 0->1 edge of the run bit restarts from the load value
  assign start   = ctrl_wr && wdata_i[0] && !ctrl_q.run_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      load_q   <= LOAD_INIT;
      ctrl_q   <= '0;
    end else begin
      if (wr_en_i && sel_lock) locked_q <= (wdata_i != KEY);
      if (load_wr)             load_q   <= wdata_i;
      if (ctrl_wr)             ctrl_q   <= ctrl_t'(wdata_i[1:0]);
    end
  end

  assign ctrl_o       = ctrl_q;
  assign reload_o     = load_wr || clr_o || start;
  assign reload_val_o = load_wr ? wdata_i : load_q;

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (1'b1)
        sel_load: rdata_o = load_q;
        sel_cur:  rdata_o = cnt_i;
        sel_ctrl: rdata_o = {{PAD_W{1'b0}}, ctrl_q.rst_en, ctrl_q.run_en};
        sel_raw:  rdata_o = {{(DATA_W-1){1'b0}}, raw_i};
        sel_mask: rdata_o = {{(DATA_W-1){1'b0}}, raw_i && ctrl_q.run_en};
        sel_lock: rdata_o = {{(DATA_W-1){1'b0}}, locked_q};
        default:  rdata_o = '0;
      endcase
    end
  end

  p_lock_open_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_lock && wdata_i == KEY) |=> !locked_q);
  p_lock_close_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_lock && wdata_i != KEY) |=> locked_q);
  p_locked_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_q && wr_en_i && sel_load) |=> $stable(load_q));
  p_locked_ctrl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_q && wr_en_i && sel_ctrl) |=> $stable(ctrl_q));
endmodule

// File: rtl/lock_wdt_count.sv
module lock_wdt_count #(
  parameter int unsigned       DATA_W    = 32,
  parameter logic [DATA_W-1:0] LOAD_INIT = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              reload_i,
  input  logic [DATA_W-1:0] reload_val_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              expire_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] cnt_q, eff_val;

  // zero period is promoted to one tick
  assign eff_val  = (reload_val_i == '0) ? ONE : reload_val_i;
  assign expire_o = en_i && !reload_i && (cnt_q <= ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= LOAD_INIT;
    else if (reload_i)    cnt_q <= eff_val;
    else if (en_i) begin
      if (cnt_q <= ONE)   cnt_q <= eff_val;
      else                cnt_q <= cnt_q - ONE;
    end
  end

  assign cnt_o = cnt_q;

  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !reload_i && cnt_q > ONE) |=> cnt_q == $past(cnt_q) - ONE);
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !reload_i) |=> $stable(cnt_q));
  p_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !reload_i && cnt_q <= ONE) |=> cnt_q == $past(eff_val));
  p_nonzero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> cnt_q != '0);
endmodule

// File: rtl/lock_wdt_expiry.sv
module lock_wdt_expiry (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic clr_i,
  input  logic rst_en_i,
  output logic raw_o,
  output logic rst_req_o
);
  logic raw_q, rst_req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      if (clr_i)         raw_q <= 1'b0;
      else if (expire_i) raw_q <= 1'b1;
      // second expiry with the interrupt still pending
      if (expire_i && raw_q && rst_en_i && !clr_i) rst_req_q <= 1'b1;
    end
  end

  assign raw_o     = raw_q;
  assign rst_req_o = rst_req_q;

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !raw_q);
  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_q |=> rst_req_q);
  p_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_q) |-> $past(raw_q && expire_i && rst_en_i));
  p_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && !clr_i) |=> raw_q);
endmodule

// File: rtl/lock_wdt.sv
module lock_wdt
  import lock_wdt_pkg::*;
#(
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       ADDR_W    = 12,
  parameter logic [DATA_W-1:0] KEY       = 32'h1ACCE551,
  parameter logic [DATA_W-1:0] LOAD_INIT = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] reload_val, cnt;
  logic              reload, clr, expire, raw;

  lock_wdt_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .KEY(KEY), .LOAD_INIT(LOAD_INIT)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i,
    .cnt_i(cnt), .raw_i(raw), .ctrl_o(ctrl), .reload_val_o(reload_val),
    .reload_o(reload), .clr_o(clr), .rdata_o
  );

  lock_wdt_count #(.DATA_W(DATA_W), .LOAD_INIT(LOAD_INIT)) u_count (
    .clk_i, .rst_ni, .en_i(ctrl.run_en), .reload_i(reload),
    .reload_val_i(reload_val), .cnt_o(cnt), .expire_o(expire)
  );

  lock_wdt_expiry u_expiry (
    .clk_i, .rst_ni, .expire_i(expire), .clr_i(clr), .rst_en_i(ctrl.rst_en),
    .raw_o(raw), .rst_req_o
  );

  assign irq_o = raw && ctrl.run_en;

  p_irq_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> raw);
endmodule

// File: tb/lock_wdt_tb_top.sv
module lock_wdt_tb_top;
  localparam logic [31:0] KEY = 32'h1ACCE551;
  localparam logic [11:0] A_LOAD = 12'h000, A_CUR = 12'h004, A_CTRL = 12'h008,
                          A_CLR = 12'h00C, A_RAW = 12'h010, A_MASK = 12'h014,
                          A_LOCK = 12'hC00;

  typedef struct {
    int          kind;   // 0 rdata, 1 irq, 2 rst_req
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, smp = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, rst_req;
  int          checks = 0, errors = 0;
  item_t       q[$];

  always #2 clk = ~clk;

  lock_wdt dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .rst_req_o(rst_req)
  );

  // monitor: samples mid low phase
  always @(negedge clk) begin
    if (smp && q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = (it.kind == 0) ? rdata : (it.kind == 1) ? {31'd0, irq} : {31'd0, rst_req};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic push_and_sample(input int kind, input logic [31:0] e, input string tag);
    item_t it;
    it.kind = kind; it.exp = e; it.tag = tag;
    q.push_back(it);
    smp = 1'b1;
    @(negedge clk); #1;
    smp = 1'b0; rd_en = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    rd_en = 1'b1; addr = a;
    push_and_sample(0, e, tag);
  endtask

  task automatic pin(input int kind, input logic e, input string tag);
    push_and_sample(kind, {31'd0, e}, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    pin(1, 1'b0, "R1 irq low");
    pin(2, 1'b0, "R1 rst_req low");
    rd(A_LOAD, 32'hFFFF_FFFF, "R1 load init");
    rd(A_CUR,  32'hFFFF_FFFF, "R1 count init");
    rd(A_CTRL, 32'h0, "R1 ctrl init");
    rd(A_LOCK, 32'h0, "R1 lock open");
    // R9/R4 load while stopped, hold
    wr(A_LOAD, 32'd5);
    rd(A_LOAD, 32'd5, "R9 load readback");
    rd(A_CUR, 32'd5, "R9 count reloaded");
    idle(3);
    rd(A_CUR, 32'd5, "R4 holds when stopped");
    // R4/R5 run
    wr(A_CTRL, 32'h1);
    rd(A_CUR, 32'd5, "R4 start value");
    rd(A_CUR, 32'd4, "R4 decrement");
    idle(2);
    rd(A_RAW, 32'd0, "R5 not yet expired");
    rd(A_RAW, 32'd1, "R5 raw after L ticks");
    rd(A_CUR, 32'd4, "R5 count reloaded");
    pin(1, 1'b1, "R6 irq high");
    rd(A_MASK, 32'd1, "R6 masked status");
    pin(2, 1'b0, "R8 no request before second expiry");
    pin(2, 1'b0, "R8 disabled request stays low");
    // R7 clear
    wr(A_CLR, 32'hDEAD_BEEF);
    rd(A_RAW, 32'd0, "R7 raw cleared");
    rd(A_CUR, 32'd4, "R7 count reloaded");
    // R4 stop and restart from load
    wr(A_CTRL, 32'h0);
    rd(A_CUR, 32'd2, "R4 stopped value");
    rd(A_CUR, 32'd2, "R4 stopped holds");
    wr(A_CTRL, 32'h1);
    rd(A_CUR, 32'd5, "R4 restart from load");
    // R8 reset request
    wr(A_CTRL, 32'h3);
    wr(A_LOAD, 32'd3);
    rd(A_CUR, 32'd3, "R9 reload on load write");
    idle(1);
    pin(1, 1'b0, "R5 irq before first expiry");
    pin(2, 1'b0, "R8 low after first expiry");
    pin(1, 1'b1, "R5 irq after first expiry");
    pin(2, 1'b0, "R8 low before second expiry");
    pin(2, 1'b1, "R8 request on second expiry");
    idle(3);
    pin(2, 1'b1, "R8 sticky");
    wr(A_CLR, 32'h0);
    pin(2, 1'b1, "R8 sticky past clear");

    do_reset();
    pin(2, 1'b0, "R1 request cleared by reset");
    wr(A_LOAD, 32'd2);
    wr(A_CTRL, 32'h1);
    wr(A_LOCK, 32'h1234_5678);
    rd(A_LOCK, 32'd1, "R2 locked");
    wr(A_CLR, 32'h0);
    rd(A_RAW, 32'd1, "R3 clear blocked");
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, 32'h1, "R3 ctrl blocked");
    wr(A_LOAD, 32'd9);
    rd(A_LOAD, 32'd2, "R3 load blocked");
    wr(A_LOCK, KEY);
    rd(A_LOCK, 32'd0, "R2 unlocked by key");
    wr(A_CTRL, 32'h0);
    rd(A_RAW, 32'd1, "R6 raw kept when stopped");
    rd(A_MASK, 32'd0, "R6 masked off");
    pin(1, 1'b0, "R6 irq masked");
    // R10 zero load
    wr(A_LOAD, 32'd0);
    wr(A_CLR, 32'h0);
    wr(A_CTRL, 32'h1);
    rd(A_RAW, 32'd0, "R10 before first tick");
    rd(A_RAW, 32'd1, "R10 expiry after one tick");
    rd(A_CUR, 32'd1, "R10 count is one");

    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual=%0d expected=0 pending", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule